// File: doc/BRIEF.md
# Sample Memory Readout and Control Register Port

This block is a bus slave for a four-channel waveform digitizer. It decodes a 16-bit offset inside the board's address window. Reads from the sample region start a read on the capture memories, which have a synchronous read port. Each returned longword packs the same sample index from all four channels. Reads of the control offset return the acquisition status. Writes to the control offsets become single-cycle strobes, plus one mode bit, for the acquisition controller.

Each access is a one-cycle request: `busSel` high at a clock edge. Read data comes back with `busRvalid` in the cycle after the request. Strobes appear in that same cycle. The mode bit takes its new value one cycle later. Accesses may be 32 or 16 bits wide and may come in any order, including while acquisition runs.

Top module: `sampbus_regport`

## Requirements
- R1: After reset `busRvalid`, `startPulse`, `stopPulse`, `clrEocPulse` and `autoStopMode` are all 0.
- R2: A 32-bit read at offset 4·n, with n in 0..2047 (offsets 0x0000–0x1FFC), drives `memAddr` = n. In the following cycle it returns the memory word with `busRvalid` high. Channel 3 is in bits 31:24, channel 2 in bits 23:16, channel 1 in bits 15:8 and channel 0 in bits 7:0.
- R3: A 16-bit read in the sample region returns a half-word in bits 15:0, with bits 31:16 zero. Offset bit 1 = 1 selects channels 3:2. Offset bit 1 = 0 selects channels 1:0.
- R4: A read at offset 0x8000 returns the address counter in bits 9:0, the EOC flag in bit 14 and the RUN flag in bit 15, with all other bits zero. The values are those present at the request edge. A 16-bit read at 0x8002 returns 0.
- R5: A write at 0x8000 with data bit 0 = 1 gives `startPulse` high for exactly the next cycle. With bit 0 = 0 it gives no pulse.
- R6: A write at 0x8004 gives `stopPulse` high for exactly the next cycle.
- R7: A write at 0x8008 gives `clrEocPulse` high for exactly the next cycle. This pulse clears EOC and serves as the trigger.
- R8: A write at 0x800C loads `autoStopMode` from data bit 0 two edges after the request. No other access changes it.
- R9: Reads of unmapped offsets (0x2000–0x7FFF, 0x8004 and above) return 0. Writes outside 0x8000/4/8/C, or with offset bit 1 set, produce no strobe and no mode change.
- R10: A sample read while `runFlag` is high returns the memory contents and produces no strobe.
- R11: 16-bit writes decode exactly like 32-bit writes, using data bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access request, one per cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busWide | input | 1 | 1 = 32-bit, 0 = 16-bit transfer |
| busOffset | input | 16 | Byte offset inside the board window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data |
| busRvalid | output | 1 | Read data valid, one cycle after request |
| memRden | output | 1 | Sample memory read enable |
| memAddr | output | 11 | Sample index to the memories |
| memRdata | input | 32 | Packed four-channel word, one cycle after enable |
| addrCount | input | 10 | Address counter of the acquisition |
| eocFlag | input | 1 | End-of-conversion flag |
| runFlag | input | 1 | Acquisition running |
| startPulse | output | 1 | Software start strobe |
| stopPulse | output | 1 | Software stop strobe |
| clrEocPulse | output | 1 | EOC clear / trigger strobe |
| autoStopMode | output | 1 | Stop-on-overrun mode bit |

## Verification
Sample reads use a memory image whose four bytes differ per index. A swapped channel order, a wrong index shift or a wrong half-word select therefore shows up as a wrong value. The indices tried are 0, 1, a middle value and 2047, the last of which tests the top address bit. Status reads use a counter pattern with alternating bits and opposite EOC/RUN values, so bit misplacement is visible. Write tests pair each control offset with its neighbours and with data bit 0 both set and clear, which shows whether the decode matches the full offset and the right data bit.

// File: rtl/sampbus_pkg.sv
package sampbus_pkg;
  typedef enum logic [1:0] {RD_NONE, RD_MEM, RD_STAT, RD_ZERO} rdKind_e;

  typedef struct packed {
    logic    start;
    logic    stop;
    logic    clrEoc;
    logic    modeLoad;
    logic    modeVal;
    rdKind_e rdKind;
    logic    rdHigh;
    logic    rdWide;
  } ctrlCmd_t;
endpackage

// File: rtl/sampbus_ctrl.sv
module sampbus_ctrl
  import sampbus_pkg::*;
#(
  parameter int OFFS_W    = 16,
  parameter int SAMPLE_AW = 11,
  parameter logic [15:0] CTRL_BASE = 16'h8000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic                 busWide,
  input  logic [OFFS_W-1:0]    busOffset,
  input  logic                 busWbit0,
  output ctrlCmd_t             cmd,
  output logic                 memRden,
  output logic [SAMPLE_AW-1:0] memAddr
);
  localparam int DATA_TOP = SAMPLE_AW + 2;

  logic dataHit, regWordHit, statHit, readReq, writeReq;
  logic [1:0] regIdx;
  ctrlCmd_t cmdNext;

  assign dataHit    = (busOffset[OFFS_W-1:DATA_TOP] == '0);
  assign regWordHit = (busOffset[OFFS_W-1:4] == CTRL_BASE[OFFS_W-1:4]) &&
                      (busOffset[1:0] == 2'b00);
  assign statHit    = (busOffset[OFFS_W-1:2] == CTRL_BASE[OFFS_W-1:2]);
  assign regIdx     = busOffset[3:2];
  assign readReq    = busSel && !busWrite;
  assign writeReq   = busSel && busWrite;

  assign memRden = readReq && dataHit;
  assign memAddr = busOffset[DATA_TOP-1:2];

  always_comb begin
    cmdNext = '0;
    if (writeReq && regWordHit) begin
      unique case (regIdx)
        2'd0: cmdNext.start = busWbit0;
        2'd1: cmdNext.stop = 1'b1;
        2'd2: cmdNext.clrEoc = 1'b1;
        default: begin
          cmdNext.modeLoad = 1'b1;
          cmdNext.modeVal  = busWbit0;
        end
      endcase
    end
    if (readReq) begin
      cmdNext.rdHigh = busOffset[1];
      cmdNext.rdWide = busWide;
      if (dataHit)      cmdNext.rdKind = RD_MEM;
      else if (statHit) cmdNext.rdKind = RD_STAT;
      else              cmdNext.rdKind = RD_ZERO;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) cmd <= '0;
    else       cmd <= cmdNext;
  end

  assert_start_needs_bit0_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmd.start |-> $past(busSel && busWrite && busWbit0));
  assert_read_answered_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite) |=> (cmd.rdKind != RD_NONE));
  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.start, cmd.stop, cmd.clrEoc, cmd.modeLoad}));
endmodule

// File: rtl/sampbus_dp.sv
module sampbus_dp
  import sampbus_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlCmd_t          cmd,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [CNT_W-1:0]  addrCount,
  input  logic              eocFlag,
  input  logic              runFlag,
  output logic [DATA_W-1:0] busRdata,
  output logic              busRvalid,
  output logic              startPulse,
  output logic              stopPulse,
  output logic              clrEocPulse,
  output logic              autoStopMode
);
  localparam int HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] statusQ;
  logic [DATA_W-1:0] word;
  logic [HALF_W-1:0] halfSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ      <= '0;
      autoStopMode <= 1'b0;
    end else begin
      statusQ <= '0;
      statusQ[HALF_W-1] <= runFlag;
      statusQ[HALF_W-2] <= eocFlag;
      statusQ[CNT_W-1:0] <= addrCount;
      if (cmd.modeLoad) autoStopMode <= cmd.modeVal;
    end
  end

  always_comb begin
    unique case (cmd.rdKind)
      RD_MEM:  word = memRdata;
      RD_STAT: word = {{(DATA_W-HALF_W){1'b0}}, statusQ};
      default: word = '0;
    endcase
  end

  assign halfSel  = cmd.rdHigh ? word[DATA_W-1:HALF_W] : word[HALF_W-1:0];
  assign busRdata = cmd.rdWide ? word : {{(DATA_W-HALF_W){1'b0}}, halfSel};
  assign busRvalid   = (cmd.rdKind != RD_NONE);
  assign startPulse  = cmd.start;
  assign stopPulse   = cmd.stop;
  assign clrEocPulse = cmd.clrEoc;

  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.modeLoad |=> $stable(autoStopMode));
  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.rdKind == RD_ZERO) |-> (busRdata == '0));
  assert_narrow_upper_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busRvalid && !cmd.rdWide) |-> (busRdata[DATA_W-1:HALF_W] == '0));
endmodule

// File: rtl/sampbus_regport.sv
module sampbus_regport
  import sampbus_pkg::*;
#(
  parameter int OFFS_W    = 16,
  parameter int SAMPLE_AW = 11,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic                 busWide,
  input  logic [OFFS_W-1:0]    busOffset,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  output logic                 busRvalid,
  output logic                 memRden,
  output logic [SAMPLE_AW-1:0] memAddr,
  input  logic [DATA_W-1:0]    memRdata,
  input  logic [CNT_W-1:0]     addrCount,
  input  logic                 eocFlag,
  input  logic                 runFlag,
  output logic                 startPulse,
  output logic                 stopPulse,
  output logic                 clrEocPulse,
  output logic                 autoStopMode
);
  ctrlCmd_t cmd;

  sampbus_ctrl #(.OFFS_W(OFFS_W), .SAMPLE_AW(SAMPLE_AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busWide(busWide), .busOffset(busOffset), .busWbit0(busWdata[0]),
    .cmd(cmd), .memRden(memRden), .memAddr(memAddr)
  );

  sampbus_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .memRdata(memRdata),
    .addrCount(addrCount), .eocFlag(eocFlag), .runFlag(runFlag),
    .busRdata(busRdata), .busRvalid(busRvalid), .startPulse(startPulse),
    .stopPulse(stopPulse), .clrEocPulse(clrEocPulse),
    .autoStopMode(autoStopMode)
  );

  assert_valid_follows_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite) |=> busRvalid);
  assert_no_read_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite) |=> !(startPulse || stopPulse || clrEocPulse));
endmodule

// File: tb/sampbus_regport_bench.sv
`timescale 1ns/1ps
module sampbus_regport_bench;
  logic clk = 1'b0;
  logic rstN;
  logic busSel, busWrite, busWide;
  logic [15:0] busOffset;
  logic [31:0] busWdata, busRdata, memRdata;
  logic busRvalid, memRden;
  logic [10:0] memAddr;
  logic [9:0] addrCount;
  logic eocFlag, runFlag, startPulse, stopPulse, clrEocPulse, autoStopMode;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sampbus_regport u_sampbus_regport (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busWide(busWide), .busOffset(busOffset), .busWdata(busWdata),
    .busRdata(busRdata), .busRvalid(busRvalid), .memRden(memRden),
    .memAddr(memAddr), .memRdata(memRdata), .addrCount(addrCount),
    .eocFlag(eocFlag), .runFlag(runFlag), .startPulse(startPulse),
    .stopPulse(stopPulse), .clrEocPulse(clrEocPulse),
    .autoStopMode(autoStopMode)
  );

  function automatic logic [31:0] memImage(input logic [10:0] n);
    return {n[7:0] ^ 8'h5A, n[10:3] + 8'h11, ~n[7:0], n[7:0] + {5'd0, n[10:8]}};
  endfunction

  always_ff @(posedge clk) if (memRden) memRdata <= memImage(memAddr);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busRead(input logic [15:0] offs, input logic wide,
                         output logic [31:0] data, output logic vld, output logic [2:0] strb);
    busSel = 1; busWrite = 0; busWide = wide; busOffset = offs;
    @(negedge clk);
    busSel = 0;
    data = busRdata; vld = busRvalid;
    strb = {startPulse, stopPulse, clrEocPulse};
  endtask

  task automatic busWriteOp(input logic [15:0] offs, input logic [31:0] d, input logic wide,
                            output logic [2:0] strb, output logic [2:0] strbNext);
    busSel = 1; busWrite = 1; busWide = wide; busOffset = offs; busWdata = d;
    @(negedge clk);
    busSel = 0; busWrite = 0;
    strb = {startPulse, stopPulse, clrEocPulse};
    @(negedge clk);
    strbNext = {startPulse, stopPulse, clrEocPulse};
  endtask

  task automatic testReset();
    check("R1 rvalid", {31'd0, busRvalid}, 32'd0);
    check("R1 strobes", {29'd0, startPulse, stopPulse, clrEocPulse}, 32'd0);
    check("R1 autoStop", {31'd0, autoStopMode}, 32'd0);
  endtask

  task automatic testWideRead();
    logic [31:0] d; logic v; logic [2:0] s;
    int idx [4] = '{0, 1, 1000, 2047};
    foreach (idx[i]) begin
      busRead(16'(idx[i] * 4), 1'b1, d, v, s);
      check("R2 valid", {31'd0, v}, 32'd1);
      check("R2 data", d, memImage(11'(idx[i])));
    end
  endtask

  task automatic testNarrowRead();
    logic [31:0] d; logic v; logic [2:0] s;
    logic [31:0] w = memImage(11'd5);
    busRead(16'h0016, 1'b0, d, v, s);
    check("R3 high half", d, {16'd0, w[31:16]});
    busRead(16'h0014, 1'b0, d, v, s);
    check("R3 low half", d, {16'd0, w[15:0]});
  endtask

  task automatic testStatus();
    logic [31:0] d; logic v; logic [2:0] s;
    addrCount = 10'h2A5; eocFlag = 1; runFlag = 0;
    busRead(16'h8000, 1'b1, d, v, s);
    check("R4 wide status", d, 32'h0000_42A5);
    addrCount = 10'h15A; eocFlag = 0; runFlag = 1;
    busRead(16'h8000, 1'b0, d, v, s);
    check("R4 narrow status", d, 32'h0000_815A);
    busRead(16'h8002, 1'b0, d, v, s);
    check("R4 narrow upper", d, 32'd0);
    runFlag = 0;
  endtask

  task automatic testStrobes();
    logic [2:0] s, n;
    busWriteOp(16'h8000, 32'h1, 1'b1, s, n);
    check("R5 start pulse", {29'd0, s}, 32'b100);
    check("R5 start one cycle", {29'd0, n}, 32'd0);
    busWriteOp(16'h8000, 32'hFFFF_FFFE, 1'b1, s, n);
    check("R5 start bit0 clear", {29'd0, s}, 32'd0);
    busWriteOp(16'h8004, 32'h0, 1'b1, s, n);
    check("R6 stop pulse", {29'd0, s}, 32'b010);
    check("R6 stop one cycle", {29'd0, n}, 32'd0);
    busWriteOp(16'h8008, 32'h0, 1'b1, s, n);
    check("R7 clear pulse", {29'd0, s}, 32'b001);
    check("R7 clear one cycle", {29'd0, n}, 32'd0);
    busWriteOp(16'h8000, 32'h1, 1'b0, s, n);
    check("R11 narrow start", {29'd0, s}, 32'b100);
    busWriteOp(16'h8008, 32'h0, 1'b0, s, n);
    check("R11 narrow clear", {29'd0, s}, 32'b001);
  endtask

  task automatic testAutoStop();
    logic [2:0] s, n;
    busWriteOp(16'h800C, 32'h1, 1'b1, s, n);
    check("R8 mode set", {31'd0, autoStopMode}, 32'd1);
    check("R8 no strobe", {29'd0, s}, 32'd0);
    busWriteOp(16'h8000, 32'h0, 1'b1, s, n);
    check("R8 mode held", {31'd0, autoStopMode}, 32'd1);
    busWriteOp(16'h800C, 32'h0, 1'b0, s, n);
    check("R8 mode cleared", {31'd0, autoStopMode}, 32'd0);
  endtask

  task automatic testUnmapped();
    logic [31:0] d; logic v; logic [2:0] s, n;
    logic [15:0] offs [4] = '{16'h2000, 16'h8004, 16'h8010, 16'hFFFC};
    foreach (offs[i]) begin
      busRead(offs[i], 1'b1, d, v, s);
      check("R9 unmapped read", d, 32'd0);
    end
    busWriteOp(16'h0010, 32'h1, 1'b1, s, n);
    check("R9 data write no strobe", {29'd0, s}, 32'd0);
    busWriteOp(16'h8010, 32'h1, 1'b1, s, n);
    check("R9 high write no strobe", {29'd0, s}, 32'd0);
    busWriteOp(16'h800E, 32'h1, 1'b0, s, n);
    check("R9 bit1 write ignored", {31'd0, autoStopMode}, 32'd0);
    busWriteOp(16'h8002, 32'h1, 1'b0, s, n);
    check("R9 bit1 start ignored", {29'd0, s}, 32'd0);
  endtask

  task automatic testRunRead();
    logic [31:0] d; logic v; logic [2:0] s;
    runFlag = 1;
    busRead(16'h0C80, 1'b1, d, v, s);
    check("R10 data during run", d, memImage(11'd800));
    check("R10 no strobe", {29'd0, s}, 32'd0);
    runFlag = 0;
  endtask

  initial begin
    rstN = 0; busSel = 0; busWrite = 0; busWide = 1; busOffset = '0; busWdata = '0;
    addrCount = '0; eocFlag = 0; runFlag = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testWideRead();
    testNarrowRead();
    testStatus();
    testStrobes();
    testAutoStop();
    testUnmapped();
    testRunRead();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule